// File: doc/BRIEF.md
# Rolling Activation Window Limiter

This block throttles row-activate commands on a DRAM channel so that no more than a set number of them fall inside any rolling window of time. Each time the scheduler issues an activate, it pulses a strobe together with the cycle count of that activate. The limiter keeps the timestamps of the most recent activates in a short shift history, newest first, so that the last slot always holds the oldest activate still being tracked.

From the oldest tracked timestamp and the programmed window length, the block works out when the next activate may go out. The result is one gate that applies to every bank and rank at once: a permit flag that compares against the free-running time, and an earliest-time value that is folded into each bank's own ready time by taking the later of the two. If an activate arrives that breaks the rule, a sticky violation flag is raised. A window length of zero turns the whole limit off.

The count limit is a parameter. Set it to 4 for a four-activate window or to 2 for a two-activate window. Timestamps are unsigned cycle counts, and every comparison is made on a difference of counts so that the rule still holds when the counter wraps.

Top module: `act_window_limiter`

## Requirements
- R1: A synchronous reset with `rst` high clears every history slot to zero and clears `violation`, `throttle` and `next_act_at`. While all slots are empty, `act_ok` is 1.
- R2: If the sampled window length is 0, `act_ok` stays 1. In that state no activate sets `throttle` or `violation`, whatever the spacing between activates.
- R3: The history holds exactly ACTS timestamps. Each strobe on `act_valid` places `act_time` in the newest slot and drops the oldest one. As a result, the activate recorded ACTS strobes ago becomes the oldest entry, and that entry drives `act_ok` and the next throttle decision.
- R4: A slot that holds the value 0 counts as empty. An empty oldest slot never causes throttling or a violation.
- R5: On an activate strobe, take the entry that will be oldest after the shift. If it is non-zero and `act_time` minus that entry is less than the window, then one cycle later `throttle` is 1 and `next_act_at` equals that entry plus the window. Otherwise `throttle` is 0 and `next_act_at` is 0. Both outputs keep their value until the next strobe.
- R6: On an activate strobe, check the oldest entry as it stands before the shift. If it is non-zero, the window is non-zero, and `act_time` minus that entry is less than the window, then `violation` is 1 from the next cycle and stays 1 until reset.
- R7: Each bank's output ready time is the later of its input ready time and `next_act_at`, judged by the sign of their 32-bit difference. When `throttle` is 0, the input ready time passes through unchanged. The limit never moves a bank's ready time earlier.
- R8: `act_ok` is 1 in any of three cases: the window is 0, the oldest slot is empty, or `now` minus the oldest entry is at least the window. Otherwise it is 0. It is a combinational function of `now` and the stored state.
- R9: `win_len` is loaded into the window register on every clock edge at which `act_valid` is 0. At an edge with `act_valid` at 1, the register keeps its previous value, and that activate is judged against the old window.
- R10: All time comparisons take the modulo-2^TS_W difference, so a window that spans the counter's wrap from all-ones back to small values throttles and flags exactly as one that does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| now | input | TS_W | Free-running current cycle count |
| act_valid | input | 1 | Strobe: one activate is issued this cycle |
| act_time | input | TS_W | Timestamp of the strobed activate (never 0) |
| win_len | input | WIN_W | Window length in cycles; 0 disables the limit |
| bank_free_in | input | BANKS*TS_W | Per-bank ready times; bank b in bits [b*TS_W +: TS_W] |
| bank_free_out | output | BANKS*TS_W | Per-bank ready times after merging the window limit |
| next_act_at | output | TS_W | Earliest time the next activate may issue while throttled |
| throttle | output | 1 | The most recent activate closed the window |
| act_ok | output | 1 | An activate issued at `now` would respect the window |
| violation | output | 1 | Sticky: an activate broke the window rule |

## Verification
A single activate strobe can do two things in the same cycle. It can trip the violation check against the oldest entry as that entry stood before the shift, and it can start a new throttle against the entry that becomes oldest after the shift. Sweeps over several windows and several fixed activate spacings drive both situations into the same edge. A reference history kept in the bench then predicts whether `violation` rises, whether `throttle` rises, and what `next_act_at` should be. The window register load and an activate strobe also meet in one cycle. This is tested by changing `win_len` while the strobe is high and checking that the resulting throttle time still uses the old window.

// File: rtl/act_window_limiter.sv
module act_window_limiter #(
  parameter int ACTS  = 4,
  parameter int TS_W  = 32,
  parameter int WIN_W = 16,
  parameter int BANKS = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [TS_W-1:0]       now,
  input  logic                  act_valid,
  input  logic [TS_W-1:0]       act_time,
  input  logic [WIN_W-1:0]      win_len,
  input  logic [BANKS*TS_W-1:0] bank_free_in,
  output logic [BANKS*TS_W-1:0] bank_free_out,
  output logic [TS_W-1:0]       next_act_at,
  output logic                  throttle,
  output logic                  act_ok,
  output logic                  violation
);

  logic [TS_W-1:0]  hist [ACTS];
  logic [WIN_W-1:0] win_q;

  wire [TS_W-1:0] oldest   = hist[ACTS-1];
  wire [TS_W-1:0] next_old = hist[ACTS-2];
  wire [TS_W-1:0] win_ext  = TS_W'(win_q);
  wire            enabled  = win_q != '0;

  wire [TS_W-1:0] gap_old  = act_time - oldest;
  wire [TS_W-1:0] gap_next = act_time - next_old;
  wire [TS_W-1:0] age      = now - oldest;

  wire too_close = enabled && (oldest != '0) && (gap_old < win_ext);
  wire must_hold = enabled && (next_old != '0) && (gap_next < win_ext);

  assign act_ok = !enabled || (oldest == '0) || (age >= win_ext);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ACTS; i++) hist[i] <= '0;
      win_q       <= '0;
      violation   <= 1'b0;
      throttle    <= 1'b0;
      next_act_at <= '0;
    end else begin
      if (!act_valid) win_q <= win_len;
      if (act_valid) begin
        hist[0] <= act_time;
        for (int i = 1; i < ACTS; i++) hist[i] <= hist[i-1];
        if (too_close) violation <= 1'b1;
        throttle    <= must_hold;
        next_act_at <= must_hold ? next_old + win_ext : '0;
      end
    end
  end

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    wire [TS_W-1:0] own  = bank_free_in[b*TS_W +: TS_W];
    wire [TS_W-1:0] lead = next_act_at - own;
    wire            push = throttle && (lead != '0) && !lead[TS_W-1];
    assign bank_free_out[b*TS_W +: TS_W] = push ? next_act_at : own;
  end

endmodule

// File: rtl/act_window_limiter_chk.sv
module act_window_limiter_chk #(
  parameter int TS_W  = 32,
  parameter int WIN_W = 16,
  parameter int BANKS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  act_valid,
  input logic [WIN_W-1:0]      win_q,
  input logic                  throttle,
  input logic                  act_ok,
  input logic                  violation,
  input logic [BANKS*TS_W-1:0] bank_free_in,
  input logic [BANKS*TS_W-1:0] bank_free_out
);

  a_r6_sticky_violation: assert property (@(posedge clk) disable iff (rst)
    violation |=> violation);

  a_r2_disabled_permits: assert property (@(posedge clk) disable iff (rst)
    (win_q == '0) |-> act_ok);

  a_r5_throttle_from_activate: assert property (@(posedge clk) disable iff (rst)
    $rose(throttle) |-> $past(act_valid));

  a_r9_window_held_on_strobe: assert property (@(posedge clk) disable iff (rst)
    act_valid |=> (win_q == $past(win_q)));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    wire [TS_W-1:0] diff = bank_free_out[b*TS_W +: TS_W] - bank_free_in[b*TS_W +: TS_W];
    a_r7_never_earlier: assert property (@(posedge clk) disable iff (rst)
      !diff[TS_W-1]);
  end

endmodule

bind act_window_limiter act_window_limiter_chk #(
  .TS_W(TS_W), .WIN_W(WIN_W), .BANKS(BANKS)
) u_chk (
  .clk(clk), .rst(rst), .act_valid(act_valid), .win_q(win_q),
  .throttle(throttle), .act_ok(act_ok), .violation(violation),
  .bank_free_in(bank_free_in), .bank_free_out(bank_free_out)
);

// File: tb/act_window_limiter_test.sv
module act_window_limiter_test;
  localparam int ACTS = 4, TS_W = 32, WIN_W = 16, BANKS = 4;

  logic clk = 0, rst = 1, act_valid = 0;
  logic [TS_W-1:0] now = 0, act_time = 0;
  logic [WIN_W-1:0] win_len = 0;
  logic [BANKS*TS_W-1:0] bank_free_in = '0;
  logic [BANKS*TS_W-1:0] bank_free_out;
  logic [TS_W-1:0] next_act_at;
  logic throttle, act_ok, violation;

  int checks = 0, errors = 0;

  logic [31:0] mh [ACTS];
  logic [31:0] mwin, mat;
  logic mhold, merr;

  always #4 clk = ~clk;

  act_window_limiter #(.ACTS(ACTS), .TS_W(TS_W), .WIN_W(WIN_W), .BANKS(BANKS)) uut (
    .clk(clk), .rst(rst), .now(now), .act_valid(act_valid), .act_time(act_time),
    .win_len(win_len), .bank_free_in(bank_free_in), .bank_free_out(bank_free_out),
    .next_act_at(next_act_at), .throttle(throttle), .act_ok(act_ok), .violation(violation));

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ACTS; i++) mh[i] = 0;
    mwin = 0; mat = 0; mhold = 0; merr = 0;
  endtask

  task automatic verify(input string tag);
    logic exp_ok;
    exp_ok = (mwin == 0) || (mh[ACTS-1] == 0) || ((now - mh[ACTS-1]) >= mwin);
    check({tag, " violation R6"}, {31'd0, violation}, {31'd0, merr});
    check({tag, " throttle R5"}, {31'd0, throttle}, {31'd0, mhold});
    check({tag, " next_act_at R5"}, next_act_at, mat);
    check({tag, " act_ok R8"}, {31'd0, act_ok}, {31'd0, exp_ok});
    for (int b = 0; b < BANKS; b++) begin
      logic [31:0] own, lead, e;
      own  = bank_free_in[b*TS_W +: TS_W];
      lead = mat - own;
      e = (mhold && lead != 0 && !lead[31]) ? mat : own;
      check({tag, " bank_free_out R7"}, bank_free_out[b*TS_W +: TS_W], e);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] t, input logic [31:0] nw,
                      input logic [WIN_W-1:0] wl, input string tag);
    @(negedge clk);
    act_valid = v; act_time = t; now = nw; win_len = wl;
    for (int b = 0; b < BANKS; b++) bank_free_in[b*TS_W +: TS_W] = nw + 32'(b * 6) - 32'd6;
    @(posedge clk);
    if (v) begin
      if (mwin != 0 && mh[ACTS-1] != 0 && (t - mh[ACTS-1]) < mwin) merr = 1;
      if (mwin != 0 && mh[ACTS-2] != 0 && (t - mh[ACTS-2]) < mwin) begin
        mhold = 1; mat = mh[ACTS-2] + mwin;
      end else begin
        mhold = 0; mat = 0;
      end
      for (int i = ACTS-1; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = t;
    end else begin
      mwin = 32'(wl);
    end
    #2;
    verify(tag);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; act_valid = 0;
    @(posedge clk); @(negedge clk); rst = 0;
    model_reset();
  endtask

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    @(posedge clk); @(posedge clk); #2;
    rst = 0;
    verify("R1 reset");
    check("R1 act_ok after reset", {31'd0, act_ok}, 32'd1);

    // R2: zero window, dense activates
    step(0, 0, 5, 0, "R2 idle");
    for (int k = 0; k < 8; k++) step(1, 32'd10 + 32'(k), 32'd10 + 32'(k), 0, "R2 dense");
    check("R2 no violation", {31'd0, violation}, 32'd0);

    // R3/R4/R5/R6/R8 directed sequence
    do_reset();
    step(0, 0, 50, 12, "R4 load window");
    step(1, 100, 100, 12, "R4 first");
    step(1, 101, 101, 12, "R4 second");
    step(1, 102, 102, 12, "R4 third");
    check("R4 no throttle with empty slot", {31'd0, throttle}, 32'd0);
    step(1, 103, 103, 12, "R5 fourth");
    check("R5 next_act_at", next_act_at, 32'd112);
    step(0, 0, 105, 12, "R8 inside window");
    check("R8 blocked", {31'd0, act_ok}, 32'd0);
    step(0, 0, 112, 12, "R8 window end");
    check("R8 permitted", {31'd0, act_ok}, 32'd1);
    step(1, 104, 113, 12, "R6 fifth close");
    check("R6 violation raised", {31'd0, violation}, 32'd1);
    step(0, 0, 200, 12, "R6 sticky");
    step(1, 400, 400, 12, "R3 later");
    check("R6 still set", {31'd0, violation}, 32'd1);

    // R9: window change during strobe is ignored
    do_reset();
    step(0, 0, 10, 20, "R9 load");
    for (int k = 0; k < 3; k++) step(1, 32'd30 + 32'(k*2), 32'd30, 20, "R9 fill");
    step(1, 36, 36, 3, "R9 strobe with new win_len");
    check("R9 old window used", next_act_at, 32'd50);

    // Sweep windows and spacings
    for (int w = 1; w <= 9; w += 2) begin
      for (int g = 1; g <= 6; g++) begin
        logic [31:0] t;
        do_reset();
        step(0, 0, 1, WIN_W'(w), "R3 sweep load");
        t = 1000;
        for (int k = 0; k < 9; k++) begin
          step(1, t, t, WIN_W'(w), "R3 sweep act");
          step(0, 0, t + 32'(g/2), WIN_W'(w), "R8 sweep idle");
          t = t + 32'(g);
        end
      end
    end

    // R10: wraparound
    do_reset();
    step(0, 0, 1, 10, "R10 load");
    step(1, 32'hFFFF_FFFA, 32'hFFFF_FFFA, 10, "R10 a");
    step(1, 32'hFFFF_FFFC, 32'hFFFF_FFFC, 10, "R10 b");
    step(1, 32'hFFFF_FFFE, 32'hFFFF_FFFE, 10, "R10 c");
    step(1, 32'h0000_0001, 32'h0000_0001, 10, "R10 d");
    check("R10 throttle across wrap", {31'd0, throttle}, 32'd1);
    check("R10 next_act_at across wrap", next_act_at, 32'h0000_0004);
    step(0, 0, 32'h0000_0002, 10, "R10 blocked");
    step(1, 32'h0000_0003, 32'h0000_0003, 10, "R10 violation");
    check("R10 violation across wrap", {31'd0, violation}, 32'd1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule